// File: doc/BRIEF.md
# Three-Target I2C Serial Memory Slave

This block is the bus-facing half of a serial byte memory. It watches an I2C bus through a fast system clock. SCL and SDA are each synchronised and edge-detected, so the block sees bus events a few system cycles after the pins change. It answers a single bus identity, and that identity reaches three separate storage targets: a main byte array of `2**ADDR_W` bytes, a `PAGE_BYTES`-byte one-time page, and an 8-bit control register. Bits 3..1 of the selection byte choose the target. The block drives SDA only by pulling it low (`sda_low_o`), so the system can build an open-drain line around it.

Writes are staged in a page-sized buffer. They land in storage only when a STOP closes the command, and `commit_o` pulses at that moment. After a commit the block is busy for `WR_CYCLES` clock cycles and refuses new selections. Reads come from the byte at the shared address pointer, and the pointer steps forward after each byte the slave sends. An external `protect_i` input blocks data writes to the array and to the one-time page. The selection and address bytes are still accepted while it is high. A repeated START discards any data still staged from the command it interrupts.

Top module: `mtm_i2c_slave`

## Requirements
- R1: The slave acknowledges a selection byte only if bits 7..4 are 1010, bits 3..1 are 000 (array), 001 (one-time page) or 100 (control register), and no write cycle is in progress. Bit 0 is the read flag, where 1 means read. Any other selection byte is not acknowledged and the slave ignores the bus until the next START.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. SDA is sampled on SCL rising edges. An acknowledge is SDA held low by the slave through the whole 9th clock, and the slave changes SDA only while SCL is low.
- R3: A write to the array or page is the selection byte, then an address high byte, then an address low byte, then data bytes. The address is the low `ADDR_W` bits of high:low, and any higher bits are ignored. Data reaches storage only at the closing STOP, and `commit_o` then pulses high for exactly one cycle. A STOP after a command that has no accepted data byte produces no pulse.
- R4: During a write, the low `log2(PAGE_BYTES)` address bits step after each data byte and wrap inside the aligned page. A later byte to the same location replaces an earlier one.
- R5: After a read selection, the slave sends bytes from the current address, starting with bit 7. A master acknowledge asks for the next byte, and a master non-acknowledge ends the read. The address steps after each byte sent and wraps from the top of the array to 0. A random read is an address-only write, then a repeated START, then a read selection.
- R6: While `protect_i` is high, data bytes for the array or page are not acknowledged and are not stored, and no commit follows. Selection and address bytes are still acknowledged, and control-register writes are not affected.
- R7: For `WR_CYCLES` cycles after a commit, every selection byte is left unacknowledged.
- R8: The one-time page uses the low 5 address bits. The first committed write to it locks it. After that, data bytes for the page are not acknowledged and the page contents stay as they were.
- R9: The control register takes data bytes straight after its write selection, with no address bytes, and updates on each acknowledged byte. A read selection returns its value. It resets to 0.
- R10: After reset, `sda_low_o` and `commit_o` are low and every storage byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| protect_i | input | 1 | High blocks data writes to the array and the page |
| sda_low_o | output | 1 | High pulls SDA low (open-drain enable) |
| commit_o | output | 1 | One-cycle pulse when staged data is committed |

## Verification
The bench builds the block with `ADDR_W = 8`, which makes a 256-byte array. That way random addresses land in a small space, rewrites and reads of the same page are frequent, and a sequential read can run across the top of the array with only a few bytes. `WR_CYCLES = 400` keeps the busy window longer than one STOP followed by a full selection byte, so a selection made straight after a commit falls inside the window. It is still short enough that the bench can wait out the window after every write. `PAGE_BYTES` stays at 32, and random write bursts of up to 34 bytes exercise the wrap inside the page.

// File: rtl/mtm_pkg.sv
package mtm_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_TACK,
        S_TNEXT
    } state_e;

    typedef enum logic [1:0] {
        P_SEL,
        P_AHI,
        P_ALO,
        P_DAT
    } phase_e;

    typedef enum logic [2:0] {
        T_ARR  = 3'b000,
        T_PAGE = 3'b001,
        T_CTRL = 3'b100
    } target_e;

    localparam logic [3:0] DEV_ID = 4'b1010;

endpackage

// File: rtl/mtm_line_mon.sv
module mtm_line_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic [1:0] scl_sync_d, scl_sync_q;
    logic [1:0] sda_sync_d, sda_sync_q;
    logic       scl_prev_d, scl_prev_q;
    logic       sda_prev_d, sda_prev_q;

    always_comb begin
        scl_sync_d = {scl_sync_q[0], scl_i};
        sda_sync_d = {sda_sync_q[0], sda_i};
        scl_prev_d = scl_sync_q[1];
        sda_prev_d = sda_sync_q[1];
    end

    // Idle bus levels are high, so reset to 1 to avoid false edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= 2'b11;
            sda_sync_q <= 2'b11;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= scl_sync_d;
            sda_sync_q <= sda_sync_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_o      = scl_sync_q[1];
    assign sda_o      = sda_sync_q[1];
    assign scl_rise_o = scl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_o & scl_prev_q;
    assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;

endmodule

// File: rtl/mtm_byte_store.sv
module mtm_byte_store #(
    parameter int AW   = 12,
    parameter int PAGE = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [AW-1:0]        base_i,
    input  logic [PAGE-1:0]      mask_i,
    input  logic [PAGE-1:0][7:0] data_i,
    input  logic [AW-1:0]        raddr_i,
    output logic [7:0]           rdata_o
);

    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem_q [DEPTH];
    logic [AW-1:0] page_base;

    assign page_base = base_i & ~AW'(PAGE - 1);

    // Behavioural storage: a whole staged page lands in one cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (we_i) begin
            for (int i = 0; i < PAGE; i++) begin
                if (mask_i[i]) mem_q[page_base | AW'(i)] <= data_i[i];
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/mtm_i2c_slave.sv
module mtm_i2c_slave
    import mtm_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PAGE_BYTES = 32,
    parameter int WR_CYCLES  = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic protect_i,
    output logic sda_low_o,
    output logic commit_o
);

    localparam int PW = $clog2(PAGE_BYTES);
    localparam int BW = $clog2(WR_CYCLES + 1);

    typedef struct packed {
        state_e                      st;
        phase_e                      ph;
        target_e                     tgt;
        logic                        rw;
        logic [3:0]                  cnt;
        logic [7:0]                  sh;
        logic [7:0]                  tx;
        logic [7:0]                  ahi;
        logic [ADDR_W-1:0]           addr;
        logic [PAGE_BYTES-1:0][7:0]  pbuf;
        logic [PAGE_BYTES-1:0]       mask;
        logic                        pend;
        logic [7:0]                  ctrl;
        logic                        locked;
        logic [BW-1:0]               busy;
        logic                        sda_low;
        logic                        commit;
    } regs_t;

    regs_t q, n;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic arr_we, page_we, ack_c;
    logic [7:0] arr_rdata, page_rdata, rd_byte;

    mtm_line_mon u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_o      (scl_s),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    assign arr_we  = bus_stop && q.pend && (q.tgt == T_ARR);
    assign page_we = bus_stop && q.pend && (q.tgt == T_PAGE);

    mtm_byte_store #(.AW(ADDR_W), .PAGE(PAGE_BYTES)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (arr_we),
        .base_i  (q.addr),
        .mask_i  (q.mask),
        .data_i  (q.pbuf),
        .raddr_i (q.addr),
        .rdata_o (arr_rdata)
    );

    mtm_byte_store #(.AW(PW), .PAGE(PAGE_BYTES)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (page_we),
        .base_i  (PW'(0)),
        .mask_i  (q.mask),
        .data_i  (q.pbuf),
        .raddr_i (q.addr[PW-1:0]),
        .rdata_o (page_rdata)
    );

    always_comb begin
        case (q.tgt)
            T_CTRL:  rd_byte = q.ctrl;
            T_PAGE:  rd_byte = page_rdata;
            default: rd_byte = arr_rdata;
        endcase
    end

    always_comb begin
        n        = q;
        n.commit = 1'b0;
        ack_c    = 1'b0;
        if (q.busy != '0) n.busy = q.busy - 1'b1;

        if (bus_stop) begin
            if (q.pend) begin
                n.commit = 1'b1;
                n.busy   = BW'(WR_CYCLES);
                if (q.tgt == T_PAGE) n.locked = 1'b1;
            end
            n.pend    = 1'b0;
            n.mask    = '0;
            n.st      = S_IDLE;
            n.sda_low = 1'b0;
        end else if (bus_start) begin
            n.st      = S_RX;
            n.ph      = P_SEL;
            n.cnt     = '0;
            n.sda_low = 1'b0;
            n.pend    = 1'b0;
            n.mask    = '0;
        end else begin
            case (q.st)
                S_RX: begin
                    if (scl_rise) begin
                        n.sh  = {q.sh[6:0], sda_s};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        case (q.ph)
                            P_SEL: begin
                                if (q.sh[7:4] == DEV_ID && q.busy == '0 &&
                                    (q.sh[3:1] == T_ARR || q.sh[3:1] == T_PAGE ||
                                     q.sh[3:1] == T_CTRL)) begin
                                    ack_c = 1'b1;
                                    n.tgt = target_e'(q.sh[3:1]);
                                    n.rw  = q.sh[0];
                                end
                            end
                            P_AHI: begin
                                ack_c = 1'b1;
                                n.ahi = q.sh;
                            end
                            P_ALO: begin
                                ack_c  = 1'b1;
                                n.addr = ADDR_W'({q.ahi, q.sh});
                            end
                            default: begin
                                if (q.tgt == T_CTRL) begin
                                    ack_c  = 1'b1;
                                    n.ctrl = q.sh;
                                end else if (!protect_i && !(q.tgt == T_PAGE && q.locked)) begin
                                    ack_c = 1'b1;
                                    n.pbuf[q.addr[PW-1:0]] = q.sh;
                                    n.mask[q.addr[PW-1:0]] = 1'b1;
                                    n.pend = 1'b1;
                                    n.addr[PW-1:0] = q.addr[PW-1:0] + 1'b1;
                                end
                            end
                        endcase
                        n.st      = ack_c ? S_ACK : S_IDLE;
                        n.sda_low = ack_c;
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        n.cnt = '0;
                        if (q.ph == P_SEL && q.rw) begin
                            n.tx      = rd_byte;
                            n.sda_low = ~rd_byte[7];
                            n.st      = S_TX;
                        end else begin
                            n.sda_low = 1'b0;
                            n.st      = S_RX;
                            case (q.ph)
                                P_SEL:   n.ph = (q.tgt == T_CTRL) ? P_DAT : P_AHI;
                                P_AHI:   n.ph = P_ALO;
                                default: n.ph = P_DAT;
                            endcase
                        end
                    end
                end
                S_TX: begin
                    if (scl_rise) begin
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            n.sda_low = 1'b0;
                            n.st      = S_TACK;
                            if (q.tgt != T_CTRL) n.addr = q.addr + 1'b1;
                        end else begin
                            n.tx      = {q.tx[6:0], 1'b0};
                            n.sda_low = ~q.tx[6];
                        end
                    end
                end
                S_TACK: begin
                    if (scl_rise) n.st = sda_s ? S_IDLE : S_TNEXT;
                end
                S_TNEXT: begin
                    if (scl_fall) begin
                        n.tx      = rd_byte;
                        n.sda_low = ~rd_byte[7];
                        n.st      = S_TX;
                        n.cnt     = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign sda_low_o = q.sda_low;
    assign commit_o  = q.commit;

endmodule

// File: rtl/mtm_i2c_checker.sv
module mtm_i2c_checker
    import mtm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_low_o,
    input logic       commit_o,
    input logic       protect_i,
    input state_e     st,
    input phase_e     ph,
    input target_e    tgt,
    input logic [7:0] sh,
    input logic       busy_zero
);

    a_r2_drive_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_o) |-> !scl_s);

    a_r1_select_match: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ACK && ph == P_SEL) |->
            (sh[7:4] == 4'b1010 &&
             (sh[3:1] == 3'b000 || sh[3:1] == 3'b001 || sh[3:1] == 3'b100)));

    a_r7_busy_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ACK && ph == P_SEL) |-> busy_zero);

    a_r6_protect_data: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_low_o) && st == S_ACK && ph == P_DAT && tgt != T_CTRL) |->
            !$past(protect_i));

    a_r3_commit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);

    a_r10_drive_states: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low_o |-> (st == S_ACK || st == S_TX));

endmodule

bind mtm_i2c_slave mtm_i2c_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_low_o (sda_low_o),
    .commit_o  (commit_o),
    .protect_i (protect_i),
    .st        (q.st),
    .ph        (q.ph),
    .tgt       (q.tgt),
    .sh        (q.sh),
    .busy_zero (q.busy == '0)
);

// File: tb/mtm_i2c_slave_test.sv
`timescale 1ns/1ps
module mtm_i2c_slave_test;

    localparam int AW  = 8;
    localparam int PB  = 32;
    localparam int WRC = 400;
    localparam int Q   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic protect = 1'b0;
    logic sda_low_o, commit_o;
    logic sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int commits = 0;

    logic [7:0] m_arr [256];
    logic [7:0] m_page [32];
    logic [7:0] wbuf [64];
    logic [7:0] rbuf [64];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_low_o;

    mtm_i2c_slave #(.ADDR_W(AW), .PAGE_BYTES(PB), .WR_CYCLES(WRC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .protect_i (protect),
        .sda_low_o (sda_low_o),
        .commit_o  (commit_o)
    );

    always @(posedge clk) if (rst_n && commit_o) commits <= commits + 1;

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_up();
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus;  tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(input logic more, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(~more);
    endtask

    // Full write: select, two address bytes, n data bytes from wbuf.
    task automatic wr_seq(input logic [7:0] dev, input logic [7:0] ahi,
                          input logic [7:0] alo, input int n);
        logic ak;
        bus_start();
        send_byte(dev, ak);  check_eq("R2 select ack low in 9th clock", ak, 1);
        send_byte(ahi, ak);  check_eq("R3 address high ack", ak, 1);
        send_byte(alo, ak);  check_eq("R3 address low ack", ak, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], ak);
            check_eq("R3 data ack", ak, 1);
        end
        bus_stop();
    endtask

    // Random read: address-only write, repeated START, read n bytes into rbuf.
    task automatic rd_seq(input logic [7:0] dev, input logic [7:0] alo, input int n);
        logic ak;
        bus_start();
        send_byte(dev, ak);          check_eq("R5 select ack", ak, 1);
        send_byte(8'h00, ak);        check_eq("R5 address high ack", ak, 1);
        send_byte(alo, ak);          check_eq("R5 address low ack", ak, 1);
        bus_start();
        send_byte(dev | 8'h01, ak);  check_eq("R5 read select ack", ak, 1);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        bus_stop();
    endtask

    task automatic model_arr(input int a, input int n);
        for (int k = 0; k < n; k++)
            m_arr[(a & 8'hE0) | ((a + k) & 31)] = wbuf[k];
    endtask

    initial begin
        logic ak;
        logic [7:0] v;
        int c0;
        void'($urandom(32'd7151));
        for (int i = 0; i < 256; i++) m_arr[i] = 8'h00;
        for (int i = 0; i < 32; i++) m_page[i] = 8'h00;

        tick(5);
        check_eq("R10 sda_low_o in reset", sda_low_o, 0);
        rst_n = 1'b1;
        tick(5);
        check_eq("R10 sda_low_o after reset", sda_low_o, 0);
        check_eq("R10 commit_o after reset", commit_o, 0);

        // R1: wrong identity and unused block code are refused
        bus_start(); send_byte(8'hB0, ak); bus_stop();
        check_eq("R1 wrong identity nack", ak, 0);
        bus_start(); send_byte(8'hA6, ak); bus_stop();
        check_eq("R1 unused block code nack", ak, 0);

        // R3: address-only write gives no commit
        c0 = commits;
        bus_start();
        send_byte(8'hA0, ak); check_eq("R1 array select ack", ak, 1);
        send_byte(8'h00, ak); send_byte(8'h10, ak);
        bus_stop(); tick(4);
        check_eq("R3 no commit without data", commits, c0);

        // R9: control register reset value, write under protect, read back
        bus_start(); send_byte(8'hA9, ak); check_eq("R9 ctrl read select ack", ak, 1);
        recv_byte(1'b0, v); bus_stop();
        check_eq("R9 ctrl reset value", v, 0);
        protect = 1'b1;
        bus_start(); send_byte(8'hA8, ak);
        send_byte(8'h5A, ak); check_eq("R9 ctrl data ack under protect (R6)", ak, 1);
        bus_stop();
        protect = 1'b0;
        bus_start(); send_byte(8'hA9, ak); recv_byte(1'b0, v); bus_stop();
        check_eq("R9 ctrl read back", v, 8'h5A);

        // R6: protected array write
        protect = 1'b1;
        c0 = commits;
        bus_start();
        send_byte(8'hA0, ak); check_eq("R6 select ack under protect", ak, 1);
        send_byte(8'h00, ak); check_eq("R6 address high ack under protect", ak, 1);
        send_byte(8'h10, ak); check_eq("R6 address low ack under protect", ak, 1);
        send_byte(8'h77, ak); check_eq("R6 data nack under protect", ak, 0);
        bus_stop(); tick(4);
        protect = 1'b0;
        check_eq("R6 no commit under protect", commits, c0);
        rd_seq(8'hA0, 8'h10, 1);
        check_eq("R6 array byte unchanged", rbuf[0], 0);

        // R4: page wrap, then R7 busy window
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        c0 = commits;
        wr_seq(8'hA0, 8'h00, 8'h3E, 4);
        model_arr(8'h3E, 4);
        tick(2);
        check_eq("R3 commit pulse after write", commits, c0 + 1);
        bus_start(); send_byte(8'hA0, ak); bus_stop();
        check_eq("R7 select nack while busy", ak, 0);
        tick(WRC + 8);
        rd_seq(8'hA0, 8'h20, 3);
        check_eq("R4 wrapped byte at page start", rbuf[0], 8'h33);
        check_eq("R4 wrapped byte second", rbuf[1], 8'h44);
        check_eq("R4 beyond wrap untouched", rbuf[2], 0);
        rd_seq(8'hA0, 8'h3E, 2);
        check_eq("R4 first bytes at page end", rbuf[0], 8'h11);
        check_eq("R4 last byte of page", rbuf[1], 8'h22);

        // R5: sequential read wraps from top of array, then current-address read
        wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
        wr_seq(8'hA0, 8'hF3, 8'hFE, 2); model_arr(8'hFE, 2); tick(WRC + 8);
        wbuf[0] = 8'hCC; wbuf[1] = 8'hDD;
        wr_seq(8'hA0, 8'h00, 8'h00, 2); model_arr(8'h00, 2); tick(WRC + 8);
        rd_seq(8'hA0, 8'hFE, 4);
        check_eq("R5 seq read FE (R3 high bits ignored)", rbuf[0], 8'hAA);
        check_eq("R5 seq read FF", rbuf[1], 8'hBB);
        check_eq("R5 seq read wraps to 00", rbuf[2], 8'hCC);
        check_eq("R5 seq read 01", rbuf[3], 8'hDD);
        bus_start(); send_byte(8'hA1, ak); recv_byte(1'b0, v); bus_stop();
        check_eq("R5 current address read", v, m_arr[2]);

        // R8: one-time page written once, then locked
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03;
        c0 = commits;
        wr_seq(8'hA2, 8'h00, 8'h05, 3); tick(2);
        check_eq("R8 page commit", commits, c0 + 1);
        tick(WRC + 8);
        rd_seq(8'hA2, 8'h05, 3);
        check_eq("R8 page byte 5", rbuf[0], 8'h01);
        check_eq("R8 page byte 6", rbuf[1], 8'h02);
        check_eq("R8 page byte 7", rbuf[2], 8'h03);
        c0 = commits;
        bus_start(); send_byte(8'hA2, ak); send_byte(8'h00, ak); send_byte(8'h05, ak);
        send_byte(8'h99, ak); bus_stop(); tick(4);
        check_eq("R8 locked page data nack", ak, 0);
        check_eq("R8 no commit when locked", commits, c0);
        rd_seq(8'hA2, 8'h05, 1);
        check_eq("R8 locked page unchanged", rbuf[0], 8'h01);
        rd_seq(8'hA0, 8'h05, 1);
        check_eq("R1 array separate from page", rbuf[0], m_arr[5]);

        // Random page writes and reads against the model (R3, R4, R5)
        for (int it = 0; it < 10; it++) begin
            int a, n, ra, rn;
            a = int'($urandom % 256);
            n = 1 + int'($urandom % 34);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            c0 = commits;
            wr_seq(8'hA0, 8'($urandom), 8'(a), n);
            model_arr(a, n);
            tick(2);
            check_eq("R3 random commit pulse", commits, c0 + 1);
            tick(WRC + 8);
            ra = ((it % 2) == 0) ? (a & 8'hE0) : int'($urandom % 256);
            rn = 1 + int'($urandom % 8);
            rd_seq(8'hA0, 8'(ra), rn);
            for (int k = 0; k < rn; k++)
                check_eq("R4 R5 random read data", rbuf[k], m_arr[(ra + k) & 255]);
        end

        finish_up();
    end

endmodule